// File: doc/BRIEF.md
# Dual Down-Counting Interval Timers

This block holds the two 16-bit interval timers of a byte-wide peripheral register file. Both counters move down by one on each clock cycle in which the tick-enable input is high. The host reaches them through single-cycle byte reads and writes at register offsets 4 to 9. The block does not hold the interrupt flags. It sends one-cycle set and clear requests, placed at fixed bit positions, to the flag register that sits beside it.

The first timer has a full 16-bit reload latch. Its counter runs down through zero to 0xFFFF and then reloads, so one period is the latch value plus two ticks. Two mode bits from the auxiliary control register choose the mode. In free-running mode it requests a flag on every period. In any other mode it requests a flag only once after each explicit load. The second timer has an 8-bit low-byte latch. It is a one-shot counter that keeps counting down past zero after it has raised its single request.

Top module: `via_timer_pair`

## Requirements
- R1: After reset, offsets 4, 5, 6, 7, 8 and 9 all read 0xFF, and `flag_set` and `flag_clr` are zero. The timer-2 low latch resets to 0x00, so writing 0xAB to offset 9 before any write to offset 8 gives a counter of 0xAB00.
- R2: On each tick, timer 1 steps down. When it is at zero it steps to 0xFFFF. On the next tick after that wrap it reloads from its latch. A counter value of 0xFFFF that came from a load is counted down as a normal value.
- R3: When `t1_mode` is 2'b01 (free-running), every tick that brings the timer-1 counter to zero raises `flag_set[6]` for one cycle, on the next cycle. Zero reached by reload counts. With any other mode value, only the first such tick after a write to offset 5 raises it.
- R4: A write to offset 4 or to offset 6 replaces only the low byte of the timer-1 latch. The counter is not touched.
- R5: A write to offset 5 sets the latch high byte and loads the counter from the whole latch in place of any tick in that cycle. It also raises `flag_clr[6]`.
- R6: A write to offset 7 sets the latch high byte and raises `flag_clr[6]`. It does not load the counter.
- R7: A read of offset 4 returns the timer-1 counter low byte and raises `flag_clr[6]`. Offsets 5, 6 and 7 return the counter high byte, the latch low byte and the latch high byte, and none of them raises a clear.
- R8: A write to offset 8 stores the timer-2 low latch. A write to offset 9 loads the timer-2 counter with {written byte, stored low latch} in place of any tick, and arms it.
- R9: Timer 2 decrements modulo 2^16 on each tick. `flag_set[5]` pulses on the cycle after the first tick that brings an armed counter to zero, and never again until the next load.
- R10: A read of offset 8 returns the timer-2 counter low byte and raises `flag_clr[5]`. A read of offset 9 returns the high byte without a clear.
- R11: Neither counter changes in a cycle with no tick and no load.
- R12: Set and clear requests appear one cycle after the event that causes them. Only bits 6 (timer 1) and 5 (timer 2) of the request vectors are ever set.
- R13: Reads of offsets other than 4 to 9 return 0x00. Writes to them change no timer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one decrement per high cycle |
| acc_valid | input | 1 | Register access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, combinational, same cycle as the read |
| t1_mode | input | 2 | Timer-1 mode bits from the auxiliary control register |
| flag_set | output | 8 | Flag set requests, bit 6 timer 1, bit 5 timer 2 |
| flag_clr | output | 8 | Flag clear requests, bit 6 timer 1, bit 5 timer 2 |

## Verification
The embedded properties assume that each access lasts exactly one cycle with a stable offset. They also assume that `t1_mode` changes only between clock edges, so that each cycle has a single mode. The bench drives all inputs in one process at the falling edge. That keeps every access a single-cycle strobe and keeps the mode constant across each rising edge. Random phases mix ticks with accesses at every offset, including ones outside the timer window, so that loads that collide with ticks and with latch writes are exercised without breaking these assumptions.

// File: rtl/via_tmr_pkg.sv
package via_tmr_pkg;

  // Register offsets; the host software decodes these positions.
  localparam int OFS_T1_CNT_LO = 4;
  localparam int OFS_T1_CNT_HI = 5;
  localparam int OFS_T1_LAT_LO = 6;
  localparam int OFS_T1_LAT_HI = 7;
  localparam int OFS_T2_CNT_LO = 8;
  localparam int OFS_T2_CNT_HI = 9;

  // Mode code of the auxiliary control bits that selects free-running.
  localparam logic [1:0] T1_MODE_FREE = 2'b01;

  // One strobe per decoded timer access.
  typedef struct packed {
    logic t1_lat_lo_wr;   // offsets 4 and 6 on write
    logic t1_hi_load_wr;  // offset 5 write
    logic t1_hi_only_wr;  // offset 7 write
    logic t1_lo_rd;       // offset 4 read
    logic t2_lat_wr;      // offset 8 write
    logic t2_load_wr;     // offset 9 write
    logic t2_lo_rd;       // offset 8 read
  } tmr_acc_t;

endpackage

// File: rtl/via_tmr_decode.sv
module via_tmr_decode
  import via_tmr_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  output tmr_acc_t      acc
);

  function automatic logic hit(input logic [AW-1:0] a, input int ofs);
    return a == AW'(ofs);
  endfunction

  logic wr_v, rd_v;
  assign wr_v = acc_valid &  acc_write;
  assign rd_v = acc_valid & ~acc_write;

  always_comb begin
    acc = '0;
    acc.t1_lat_lo_wr  = wr_v & (hit(acc_addr, OFS_T1_CNT_LO) | hit(acc_addr, OFS_T1_LAT_LO));
    acc.t1_hi_load_wr = wr_v & hit(acc_addr, OFS_T1_CNT_HI);
    acc.t1_hi_only_wr = wr_v & hit(acc_addr, OFS_T1_LAT_HI);
    acc.t1_lo_rd      = rd_v & hit(acc_addr, OFS_T1_CNT_LO);
    acc.t2_lat_wr     = wr_v & hit(acc_addr, OFS_T2_CNT_LO);
    acc.t2_load_wr    = wr_v & hit(acc_addr, OFS_T2_CNT_HI);
    acc.t2_lo_rd      = rd_v & hit(acc_addr, OFS_T2_CNT_LO);
  end

endmodule

// File: rtl/via_t1_core.sv
module via_t1_core #(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_en,
  input  logic           free_run,
  input  logic           wr_lat_lo,
  input  logic           wr_hi_load,
  input  logic           wr_hi_only,
  input  logic [DW-1:0]  wdata,
  output logic [2*DW-1:0] cnt_o,
  output logic [2*DW-1:0] latch_o,
  output logic           fire_o
);

  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q, latch_q;
  logic          past_zero_q;  // counter sits on the wrap value after zero
  logic          armed_q;
  logic          fire_q;

  // Next {past_zero, count} for one tick.
  function automatic logic [CW:0] t1_step(input logic [CW-1:0] c,
                                          input logic          pz,
                                          input logic [CW-1:0] lat);
    if (pz)             return {1'b0, lat};
    else if (c == '0)   return {1'b1, {CW{1'b1}}};
    else                return {1'b0, c - 1'b1};
  endfunction

  logic [CW:0]   step_w;
  logic          tick_go;      // tick not overridden by a load
  logic          reach_zero;   // this tick lands the counter on zero
  logic          fire_now;
  logic [CW-1:0] load_val;

  assign step_w     = t1_step(cnt_q, past_zero_q, latch_q);
  assign tick_go    = tick_en & ~wr_hi_load;
  assign reach_zero = tick_go & ~step_w[CW] & (step_w[CW-1:0] == '0);
  assign fire_now   = reach_zero & (free_run | armed_q);
  assign load_val   = {wdata, latch_q[DW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q       <= '1;
      latch_q     <= '1;
      past_zero_q <= 1'b0;
      armed_q     <= 1'b0;
      fire_q      <= 1'b0;
    end else begin
      fire_q <= fire_now;
      if (wr_lat_lo)
        latch_q[DW-1:0] <= wdata;
      if (wr_hi_load || wr_hi_only)
        latch_q[CW-1:DW] <= wdata;
      if (wr_hi_load) begin
        cnt_q       <= load_val;
        past_zero_q <= 1'b0;
        armed_q     <= 1'b1;
      end else if (tick_en) begin
        cnt_q       <= step_w[CW-1:0];
        past_zero_q <= step_w[CW];
        if (reach_zero)
          armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign latch_o = latch_q;
  assign fire_o  = fire_q;

  AST_T1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_hi_load) |=> $stable(cnt_q)); // R11
  AST_T1_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_hi_load && past_zero_q) |=> (cnt_q == $past(latch_q))); // R2
  AST_T1_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !wr_hi_load && !past_zero_q && cnt_q == '0) |=> (cnt_q == '1)); // R2
  AST_T1_FIRE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == '0 && !past_zero_q)); // R3
  AST_T1_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi_load |=> (cnt_q == {$past(wdata), $past(latch_q[DW-1:0])})); // R5
  AST_T1_HI_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi_only && !tick_en) |=> (latch_q[CW-1:DW] == $past(wdata) && $stable(cnt_q))); // R6

endmodule

// File: rtl/via_t2_core.sv
module via_t2_core #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick_en,
  input  logic            wr_lat,
  input  logic            wr_load,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cnt_o,
  output logic            fire_o
);

  localparam int CW = 2 * DW;

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] lat_q;
  logic          armed_q;
  logic          fire_q;

  function automatic logic [CW-1:0] t2_step(input logic [CW-1:0] c);
    return c - 1'b1;
  endfunction

  logic [CW-1:0] next_w;
  logic          tick_go;
  logic          fire_now;

  assign next_w   = t2_step(cnt_q);
  assign tick_go  = tick_en & ~wr_load;
  assign fire_now = tick_go & armed_q & (next_w == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      lat_q   <= '0;
      armed_q <= 1'b0;
      fire_q  <= 1'b0;
    end else begin
      fire_q <= fire_now;
      if (wr_lat)
        lat_q <= wdata;
      if (wr_load) begin
        cnt_q   <= {wdata, lat_q};
        armed_q <= 1'b1;
      end else if (tick_en) begin
        cnt_q <= next_w;
        if (fire_now)
          armed_q <= 1'b0;
      end
    end
  end

  assign cnt_o  = cnt_q;
  assign fire_o = fire_q;

  AST_T2_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_q |-> (cnt_q == '0 && !armed_q)); // R9
  AST_T2_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_load |=> (cnt_q == {$past(wdata), $past(lat_q)} && armed_q)); // R8
  AST_T2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !wr_load) |=> $stable(cnt_q)); // R11

endmodule

// File: rtl/via_timer_pair.sv
module via_timer_pair
  import via_tmr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 4,
  parameter int T1_BIT = 6,
  parameter int T2_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] acc_wdata,
  output logic [DW-1:0] acc_rdata,
  input  logic [1:0]    t1_mode,
  output logic [DW-1:0] flag_set,
  output logic [DW-1:0] flag_clr
);

  localparam int CW = 2 * DW;
  localparam logic [DW-1:0] FLAG_MASK = (DW'(1) << T1_BIT) | (DW'(1) << T2_BIT);

  tmr_acc_t      acc;
  logic [CW-1:0] t1_cnt, t1_lat, t2_cnt;
  logic          t1_fire, t2_fire;
  logic          t1_clr_q, t2_clr_q;
  logic          free_run;

  assign free_run = (t1_mode == T1_MODE_FREE);

  via_tmr_decode #(.AW(AW)) u_dec (
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc       (acc)
  );

  via_t1_core #(.DW(DW)) u_t1 (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_en    (tick_en),
    .free_run   (free_run),
    .wr_lat_lo  (acc.t1_lat_lo_wr),
    .wr_hi_load (acc.t1_hi_load_wr),
    .wr_hi_only (acc.t1_hi_only_wr),
    .wdata      (acc_wdata),
    .cnt_o      (t1_cnt),
    .latch_o    (t1_lat),
    .fire_o     (t1_fire)
  );

  via_t2_core #(.DW(DW)) u_t2 (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_lat  (acc.t2_lat_wr),
    .wr_load (acc.t2_load_wr),
    .wdata   (acc_wdata),
    .cnt_o   (t2_cnt),
    .fire_o  (t2_fire)
  );

  // Clear requests from the accesses that acknowledge each timer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_clr_q <= 1'b0;
      t2_clr_q <= 1'b0;
    end else begin
      t1_clr_q <= acc.t1_hi_load_wr | acc.t1_hi_only_wr | acc.t1_lo_rd;
      t2_clr_q <= acc.t2_lo_rd;
    end
  end

  for (genvar b = 0; b < DW; b++) begin : g_flag
    if (b == T1_BIT) begin : g_t1
      assign flag_set[b] = t1_fire;
      assign flag_clr[b] = t1_clr_q;
    end else if (b == T2_BIT) begin : g_t2
      assign flag_set[b] = t2_fire;
      assign flag_clr[b] = t2_clr_q;
    end else begin : g_none
      assign flag_set[b] = 1'b0;
      assign flag_clr[b] = 1'b0;
    end
  end

  // Read data path.
  always_comb begin
    acc_rdata = '0;
    if (acc_valid && !acc_write) begin
      if      (acc_addr == AW'(OFS_T1_CNT_LO)) acc_rdata = t1_cnt[DW-1:0];
      else if (acc_addr == AW'(OFS_T1_CNT_HI)) acc_rdata = t1_cnt[CW-1:DW];
      else if (acc_addr == AW'(OFS_T1_LAT_LO)) acc_rdata = t1_lat[DW-1:0];
      else if (acc_addr == AW'(OFS_T1_LAT_HI)) acc_rdata = t1_lat[CW-1:DW];
      else if (acc_addr == AW'(OFS_T2_CNT_LO)) acc_rdata = t2_cnt[DW-1:0];
      else if (acc_addr == AW'(OFS_T2_CNT_HI)) acc_rdata = t2_cnt[CW-1:DW];
    end
  end

  AST_FLAG_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag_set & ~FLAG_MASK) == '0 && (flag_clr & ~FLAG_MASK) == '0)); // R12
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc)); // R13
  AST_T1_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_addr == AW'(OFS_T1_CNT_HI)) |=> !flag_clr[T1_BIT]); // R7
  AST_T2_CLR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr == AW'(OFS_T2_CNT_LO) && !acc_write) |=> flag_clr[T2_BIT]); // R10

endmodule

// File: tb/sim_via_timer_pair.sv
`timescale 1ns/100ps
module sim_via_timer_pair;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       acc_valid = 1'b0;
  logic       acc_write = 1'b0;
  logic [3:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic [1:0] t1_mode = 2'b00;
  logic [7:0] flag_set, flag_clr;

  always #2.5 clk = ~clk;

  via_timer_pair u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .t1_mode(t1_mode), .flag_set(flag_set), .flag_clr(flag_clr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural reference: timer 1 uses -1 for the wrapped state.
  int m_c1 = 65535, m_l1 = 65535, m_c2 = 65535, m_l2 = 0;
  bit m_arm1 = 0, m_arm2 = 0;
  bit e_s1 = 0, e_s2 = 0, e_c1 = 0, e_c2 = 0;
  int lfsr = 32'h1ACE5;

  function automatic int model_read(int a);
    int v1;
    v1 = (m_c1 < 0) ? 65535 : m_c1;
    case (a)
      4: return v1 % 256;
      5: return v1 / 256;
      6: return m_l1 % 256;
      7: return m_l1 / 256;
      8: return m_c2 % 256;
      9: return m_c2 / 256;
      default: return 0;
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit tk, bit v, bit w, int a, int d);
    e_c1 = v && ((w && (a == 5 || a == 7)) || (!w && a == 4));
    e_c2 = v && !w && a == 8;
    e_s1 = 0; e_s2 = 0;
    if (v && w && a == 5) begin
      m_l1 = d * 256 + (m_l1 % 256);
      m_c1 = m_l1;
      m_arm1 = 1;
    end else if (tk) begin
      if (m_c1 == -1) m_c1 = m_l1; else m_c1 = m_c1 - 1;
      if (m_c1 == 0) begin
        if (t1_mode == 2'b01 || m_arm1) e_s1 = 1;
        m_arm1 = 0;
      end
    end
    if (v && w && (a == 4 || a == 6)) m_l1 = (m_l1 / 256) * 256 + d;
    if (v && w && a == 7) m_l1 = d * 256 + (m_l1 % 256);
    if (v && w && a == 9) begin
      m_c2 = d * 256 + m_l2;
      m_arm2 = 1;
    end else if (tk) begin
      m_c2 = (m_c2 + 65535) % 65536;
      if (m_c2 == 0 && m_arm2) begin e_s2 = 1; m_arm2 = 0; end
    end
    if (v && w && a == 8) m_l2 = d;
  endtask

  // One cycle: drive at falling edge, check read data, clock, check requests.
  task automatic step(string tag, bit tk, bit v = 0, bit w = 0, int a = 0, int d = 0);
    tick_en = tk; acc_valid = v; acc_write = w; acc_addr = a[3:0]; acc_wdata = d[7:0];
    #1;
    if (v && !w) check({tag, " rdata"}, acc_rdata, model_read(a));
    @(posedge clk);
    model_edge(tk, v, w, a, d);
    @(negedge clk);
    check({tag, " flag_set"}, flag_set, (e_s1 << 6) | (e_s2 << 5));
    check({tag, " flag_clr"}, flag_clr, (e_c1 << 6) | (e_c2 << 5));
    tick_en = 0; acc_valid = 0; acc_write = 0;
  endtask

  task automatic rd(string tag, int a, bit tk = 0); step(tag, tk, 1, 0, a, 0); endtask
  task automatic wr(string tag, int a, int d, bit tk = 0); step(tag, tk, 1, 1, a, d); endtask

  function automatic int rnd(int n);
    lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
    return (lfsr & 32'h7fffffff) % n;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1 flag_set in reset", flag_set, 0);
    check("R1 flag_clr in reset", flag_clr, 0);
    rst_n = 1'b1;
    for (int a = 4; a <= 9; a++) rd("R1 reset read", a);
    rd("R13 unmapped read", 2);
    wr("R13 unmapped write", 12, 8'h5A);
    wr("R1 t2 latch zero", 9, 8'hAB);
    rd("R1 t2 low after load", 8);
    rd("R1 t2 high after load", 9);

    // Timer 1 one-shot, latch 5, period 7.
    t1_mode = 2'b00;
    wr("R4 latch low", 4, 5);
    wr("R5 load", 5, 0);
    for (int i = 0; i < 20; i++) rd("R3 R2 one-shot count", 5, 1);
    rd("R7 latch lo read", 6);
    rd("R7 latch hi read", 7);
    rd("R7 counter lo read", 4);

    // Free-running, latch 3.
    t1_mode = 2'b01;
    wr("R4 latch low via 6", 6, 3);
    wr("R5 load free", 5, 0, 1);
    for (int i = 0; i < 24; i++) rd("R3 free-run period", 4, 1);
    wr("R4 latch low during count", 6, 9, 1);
    for (int i = 0; i < 6; i++) rd("R4 counter unaffected", 4, 1);
    wr("R6 high only", 7, 0, 1);
    for (int i = 0; i < 14; i++) rd("R6 no reload", 4, 1);

    // Latch zero: period two.
    wr("R2 latch zero lo", 4, 0);
    wr("R2 latch zero load", 5, 0);
    for (int i = 0; i < 8; i++) step("R2 period two", 1);
    t1_mode = 2'b10;
    wr("R3 one-shot mode 10 load", 5, 0);
    for (int i = 0; i < 8; i++) rd("R3 mode 10 once", 4, 1);
    t1_mode = 2'b11;
    wr("R3 mode 11 latch", 4, 2);
    wr("R3 mode 11 load", 5, 0);
    for (int i = 0; i < 12; i++) rd("R3 mode 11 once", 5, 1);

    // Sparse ticks, load collides with tick.
    for (int i = 0; i < 8; i++) rd("R11 no tick hold", 4, 0);
    wr("R11 load wins over tick", 5, 1, 1);
    rd("R11 load value", 5);

    // Timer 2.
    wr("R8 t2 low latch", 8, 3);
    wr("R8 t2 load", 9, 0);
    for (int i = 0; i < 10; i++) rd("R9 t2 one-shot", 9, 1);
    rd("R10 t2 low read", 8);
    rd("R10 t2 high read", 9);
    wr("R8 t2 load with tick", 9, 0, 1);
    for (int i = 0; i < 6; i++) rd("R9 t2 rearm", 8, 1);

    // Random mix of ticks and accesses at any offset.
    for (int i = 0; i < 1500; i++) begin
      int a, k;
      if (i % 200 == 0) t1_mode = rnd(4);
      a = (rnd(4) == 0) ? rnd(16) : 4 + rnd(6);
      k = rnd(8);
      if (k < 3) step("R12 random idle", rnd(2));
      else if (k < 6) rd("R12 random read", a, rnd(2));
      else wr("R13 random write", a, (rnd(3) == 0) ? 0 : rnd(8), rnd(2));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule